// File: doc/BRIEF.md
# I2C Slave Acknowledge Controller

This block decides the response a bus slave gives in the acknowledge slot that follows every byte. It works from one-cycle strobes supplied by the rest of the slave: SCL rising and falling edge events, a byte-complete strobe that coincides with the eighth falling SCL edge, an indication that the slave is selected, and whether the byte just completed was an address byte or a data byte. An acknowledge is active low: the block asserts an SDA pull-low enable for the ninth clock when it accepts a byte.

Two hold enables choose the source of the response, one for address bytes and one for data bytes. When the applicable enable is clear, the hardware acknowledges at once. When it is set, the block raises an acknowledge-time flag, holds SCL low, and waits for software to write an acknowledge data bit and a release strobe. The block keeps a buffer-full flag and an overflow flag. When either flag is set as a byte arrives, the block answers with a NACK by leaving SDA released. When the slave is transmitting, the block leaves SDA released in the ninth clock and captures the master's response into an acknowledge-status output.

Top module: `i2cAckUnit`

## Requirements
- R1: After reset, sdaPullLow, sclHoldLow, ackTime, ackStatus, bufFull and overflow are all 0.
- R2: When a receive byte completes (byteDone with addressed=1 and txMode=0), the applicable hold enable is clear, and bufFull and overflow are both 0, sdaPullLow is 1 from the cycle after byteDone. It returns to 0 in the cycle after the first sclFall that follows an sclRise.
- R3: The applicable hold enable is addrHoldEn when isAddrByte=1 and dataHoldEn when isAddrByte=0. The other enable has no effect on that byte.
- R4: When a receive byte completes with the applicable hold enable set and bufFull and overflow both 0, sclHoldLow and ackTime are 1 from the cycle after byteDone. They stay 1, with sdaPullLow at 0, until swRelease.
- R5: A swRelease during a hold clears sclHoldLow and ackTime in the next cycle. In that same cycle, sdaPullLow becomes 1 if swAckData=0 (ACK) and stays 0 if swAckData=1 (NACK). sdaPullLow is removed as in R2.
- R6: A receive byte that arrives while bufFull or overflow is 1 gets a NACK: no sdaPullLow and no sclHoldLow. If the applicable hold enable is set, ackTime is still 1, and it clears after the falling SCL edge that ends the ninth clock.
- R7: ackTime is never set for a byte whose applicable hold enable is clear, and it is never set for a transmit byte.
- R8: Every receive byte sets bufFull. A receive byte that arrives while bufFull is already 1 also sets overflow.
- R9: clrBufFull and clrOverflow clear their flags in the next cycle. A byte arriving in the same cycle is judged against the flags as they were before the clear, and the set wins.
- R10: For a transmit byte (addressed=1, txMode=1), sdaPullLow stays 0 through the ninth clock. ackStatus takes sdaIn at the ninth sclRise (0 means ACK, 1 means NACK) and keeps its value otherwise. bufFull and overflow do not change.
- R11: A byteDone with addressed=0 is ignored: no sdaPullLow, no sclHoldLow, no ackTime, and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclRise | input | 1 | One-cycle strobe for a rising SCL edge |
| sclFall | input | 1 | One-cycle strobe for a falling SCL edge |
| sdaIn | input | 1 | Sampled SDA level, used for the master's response |
| byteDone | input | 1 | Strobe at the eighth falling SCL edge of a byte |
| isAddrByte | input | 1 | The completed byte is an address byte |
| addressed | input | 1 | The slave is selected for this byte |
| txMode | input | 1 | The slave is transmitting this byte |
| addrHoldEn | input | 1 | Software decides the response to address bytes |
| dataHoldEn | input | 1 | Software decides the response to data bytes |
| swAckData | input | 1 | Software response: 0 = ACK, 1 = NACK |
| swRelease | input | 1 | Software strobe that ends a hold |
| clrBufFull | input | 1 | Clears bufFull |
| clrOverflow | input | 1 | Clears overflow |
| sdaPullLow | output | 1 | Enable that drives SDA low |
| sclHoldLow | output | 1 | Enable that holds SCL low |
| ackTime | output | 1 | Acknowledge-time flag |
| ackStatus | output | 1 | Master's response to the last transmitted byte |
| bufFull | output | 1 | Received byte not yet taken |
| overflow | output | 1 | A byte arrived while the buffer was full |

## Verification
The assertions check on every cycle that a hold never coincides with a pull of SDA, that the pull is removed only on a falling SCL edge, and that a hold ends only on a software release. They also check that a full or overflowed buffer always produces a NACK, that overflow rises only over a full buffer, and that ackTime rises only when the applicable hold enable is set. Only the bench's scenarios show end-to-end behaviour. That covers the response level chosen through a hold, the choice between the address and data enables, the precedence when a clear and a new byte meet in one cycle, and the capture of the master's response in transmit.

// File: rtl/i2cAckPkg.sv
package i2cAckPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HOLD   = 2'd1,
    ST_SLOT   = 2'd2,
    ST_TXSLOT = 2'd3
  } ackState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptByte;
    logic pullOn;
    logic pullOff;
    logic holdOn;
    logic holdOff;
    logic timeSet;
    logic timeClr;
    logic sampleAck;
  } ackCtrl_t;

endpackage

// File: rtl/i2cAckFsm.sv
module i2cAckFsm
  import i2cAckPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      byteDone,
  input  logic      isAddrByte,
  input  logic      addressed,
  input  logic      txMode,
  input  logic      addrHoldEn,
  input  logic      dataHoldEn,
  input  logic      swAckData,
  input  logic      swRelease,
  input  logic      bufFull,
  input  logic      overflow,
  output ackCtrl_t  ctrl,
  output ackState_t state
);

  ackState_t stateNext;
  logic      seenRise;
  logic      seenRiseNext;
  logic      holdSel;
  logic      forcedNack;
  logic      rxByte;
  logic      txByte;

  assign holdSel    = isAddrByte ? addrHoldEn : dataHoldEn;
  assign forcedNack = bufFull | overflow;
  assign rxByte     = byteDone & addressed & ~txMode & (state == ST_IDLE);
  assign txByte     = byteDone & addressed &  txMode & (state == ST_IDLE);

  always_comb begin
    ctrl         = '0;
    stateNext    = state;
    seenRiseNext = seenRise;
    unique case (state)
      ST_IDLE: begin
        seenRiseNext = 1'b0;
        if (rxByte) begin
          ctrl.acceptByte = 1'b1;
          ctrl.timeSet    = holdSel;
          ctrl.pullOn     = ~forcedNack & ~holdSel;
          if (~forcedNack && holdSel) begin
            ctrl.holdOn = 1'b1;
            stateNext   = ST_HOLD;
          end else begin
            stateNext   = ST_SLOT;
          end
        end else if (txByte) begin
          stateNext = ST_TXSLOT;
        end
      end
      ST_HOLD: begin
        if (swRelease) begin
          ctrl.holdOff = 1'b1;
          ctrl.timeClr = 1'b1;
          ctrl.pullOn  = ~swAckData;
          stateNext    = ST_SLOT;
        end
      end
      ST_SLOT: begin
        if (sclRise) seenRiseNext = 1'b1;
        if (sclFall && seenRise) begin
          ctrl.pullOff = 1'b1;
          ctrl.timeClr = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      ST_TXSLOT: begin
        if (sclRise && !seenRise) begin
          ctrl.sampleAck = 1'b1;
          seenRiseNext   = 1'b1;
        end
        if (sclFall && seenRise) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      seenRise <= 1'b0;
    end else begin
      state    <= stateNext;
      seenRise <= seenRiseNext;
    end
  end

  // a hold is entered only from the byte strobe of an accepted byte (R4)
  assert_hold_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_HOLD) ##1 (state == ST_HOLD) |-> $past(byteDone & addressed & ~txMode));

endmodule

// File: rtl/i2cAckFlags.sv
module i2cAckFlags
  import i2cAckPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  ackCtrl_t ctrl,
  input  logic     sdaIn,
  input  logic     clrBufFull,
  input  logic     clrOverflow,
  output logic     sdaPullLow,
  output logic     sclHoldLow,
  output logic     ackTime,
  output logic     ackStatus,
  output logic     bufFull,
  output logic     overflow
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufFull  <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (ctrl.acceptByte)   bufFull <= 1'b1;
      else if (clrBufFull)   bufFull <= 1'b0;
      if (ctrl.acceptByte && bufFull) overflow <= 1'b1;
      else if (clrOverflow)           overflow <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaPullLow <= 1'b0;
      sclHoldLow <= 1'b0;
      ackTime    <= 1'b0;
      ackStatus  <= 1'b0;
    end else begin
      if (ctrl.pullOn)       sdaPullLow <= 1'b1;
      else if (ctrl.pullOff) sdaPullLow <= 1'b0;
      if (ctrl.holdOn)       sclHoldLow <= 1'b1;
      else if (ctrl.holdOff) sclHoldLow <= 1'b0;
      if (ctrl.timeSet)      ackTime    <= 1'b1;
      else if (ctrl.timeClr) ackTime    <= 1'b0;
      if (ctrl.sampleAck)    ackStatus  <= sdaIn;
    end
  end

  assert_ovf_needs_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(bufFull));

endmodule

// File: rtl/i2cAckUnit.sv
module i2cAckUnit
  import i2cAckPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic sclRise,
  input  logic sclFall,
  input  logic sdaIn,
  input  logic byteDone,
  input  logic isAddrByte,
  input  logic addressed,
  input  logic txMode,
  input  logic addrHoldEn,
  input  logic dataHoldEn,
  input  logic swAckData,
  input  logic swRelease,
  input  logic clrBufFull,
  input  logic clrOverflow,
  output logic sdaPullLow,
  output logic sclHoldLow,
  output logic ackTime,
  output logic ackStatus,
  output logic bufFull,
  output logic overflow
);

  ackCtrl_t  ctrl;
  ackState_t state;

  i2cAckFsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .sclRise    (sclRise),
    .sclFall    (sclFall),
    .byteDone   (byteDone),
    .isAddrByte (isAddrByte),
    .addressed  (addressed),
    .txMode     (txMode),
    .addrHoldEn (addrHoldEn),
    .dataHoldEn (dataHoldEn),
    .swAckData  (swAckData),
    .swRelease  (swRelease),
    .bufFull    (bufFull),
    .overflow   (overflow),
    .ctrl       (ctrl),
    .state      (state)
  );

  i2cAckFlags u_flags (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .sdaIn       (sdaIn),
    .clrBufFull  (clrBufFull),
    .clrOverflow (clrOverflow),
    .sdaPullLow  (sdaPullLow),
    .sclHoldLow  (sclHoldLow),
    .ackTime     (ackTime),
    .ackStatus   (ackStatus),
    .bufFull     (bufFull),
    .overflow    (overflow)
  );

  logic idleNow;
  logic holdPick;
  assign idleNow  = (state == ST_IDLE);
  assign holdPick = isAddrByte ? addrHoldEn : dataHoldEn;

  assert_auto_ack_R2: assert property (@(posedge clk) disable iff (!rstN)
    (idleNow && byteDone && addressed && !txMode && !bufFull && !overflow && !holdPick)
      |=> sdaPullLow);

  assert_pull_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> $past(sclFall));

  assert_hold_no_pull_R4: assert property (@(posedge clk) disable iff (!rstN)
    sclHoldLow |-> !sdaPullLow);

  assert_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclHoldLow) |-> $past(swRelease));

  assert_forced_nack_R6: assert property (@(posedge clk) disable iff (!rstN)
    (idleNow && byteDone && addressed && !txMode && (bufFull || overflow))
      |=> (!sdaPullLow && !sclHoldLow));

  assert_acktime_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackTime) |-> $past(holdPick && !txMode));

  assert_tx_no_pull_R10: assert property (@(posedge clk) disable iff (!rstN)
    (idleNow && byteDone && addressed && txMode) |=> !sdaPullLow);

endmodule

// File: tb/test_i2cAckUnit.sv
`timescale 1ns/100ps
module test_i2cAckUnit;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclRise = 0, sclFall = 0, sdaIn = 0, byteDone = 0, isAddrByte = 0;
  logic addressed = 0, txMode = 0, addrHoldEn = 0, dataHoldEn = 0;
  logic swAckData = 0, swRelease = 0, clrBufFull = 0, clrOverflow = 0;
  logic sdaPullLow, sclHoldLow, ackTime, ackStatus, bufFull, overflow;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  // bench model of the flags
  bit mBuf = 0, mOvf = 0, mAckSt = 0;

  always #2.5 clk = ~clk;

  i2cAckUnit i_i2cAckUnit (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall), .sdaIn(sdaIn),
    .byteDone(byteDone), .isAddrByte(isAddrByte), .addressed(addressed),
    .txMode(txMode), .addrHoldEn(addrHoldEn), .dataHoldEn(dataHoldEn),
    .swAckData(swAckData), .swRelease(swRelease), .clrBufFull(clrBufFull),
    .clrOverflow(clrOverflow), .sdaPullLow(sdaPullLow), .sclHoldLow(sclHoldLow),
    .ackTime(ackTime), .ackStatus(ackStatus), .bufFull(bufFull), .overflow(overflow)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  function automatic bit pickHold(bit isA, bit hA, bit hD);
    return isA ? hA : hD;
  endfunction

  function automatic bit expForced(bit rx, bit b, bit o);
    return rx & (b | o);
  endfunction

  task automatic checkFlags(input string tag);
    chk({tag, " bufFull"}, bufFull, mBuf);
    chk({tag, " overflow"}, overflow, mOvf);
  endtask

  // one byte followed by its ninth clock
  task automatic runByte(input bit a, input bit tx, input bit isA, input bit hA,
                         input bit hD, input bit swAck, input int waitCyc,
                         input bit sdaM, input bit cB, input bit cO);
    bit rx, hold, forced;
    rx     = a & ~tx;
    hold   = pickHold(isA, hA, hD);
    forced = expForced(rx, mBuf, mOvf);
    addressed = a; txMode = tx; isAddrByte = isA; addrHoldEn = hA; dataHoldEn = hD;
    clrBufFull = cB; clrOverflow = cO;
    byteDone = 1;
    tick;
    byteDone = 0; clrBufFull = 0; clrOverflow = 0;
    // R9: judged on old flags, set wins over clear
    if (rx) begin
      if (mBuf) mOvf = 1; else if (cO) mOvf = 0;
      mBuf = 1;
    end else begin
      if (cB) mBuf = 0;
      if (cO) mOvf = 0;
    end
    checkFlags("R8/R9/R11 after byte");
    chk("R2/R6/R10/R11 pull after byte", sdaPullLow, rx & ~forced & ~hold);
    chk("R4/R6 hold after byte", sclHoldLow, rx & ~forced & hold);
    chk("R3/R7 ackTime after byte", ackTime, rx & hold);
    if (rx & ~forced & hold) begin
      for (int i = 0; i < waitCyc; i++) tick;
      chk("R4 still holding", sclHoldLow, 1'b1);
      chk("R4 no pull while holding", sdaPullLow, 1'b0);
      swAckData = swAck;
      swRelease = 1;
      tick;
      swRelease = 0;
      chk("R5 hold released", sclHoldLow, 1'b0);
      chk("R5 ackTime cleared", ackTime, 1'b0);
      chk("R5 pull from swAckData", sdaPullLow, ~swAck);
    end
    sdaIn = sdaM;
    sclRise = 1;
    tick;
    sclRise = 0;
    if (a & tx) mAckSt = sdaM;
    chk("R10 ackStatus", ackStatus, mAckSt);
    chk("R10 no pull in tx slot", sdaPullLow, rx & ~forced & (hold ? ~swAck : 1'b1));
    tick;
    sclFall = 1;
    tick;
    sclFall = 0;
    chk("R2/R5 pull removed after ninth clock", sdaPullLow, 1'b0);
    chk("R6 ackTime cleared after slot", ackTime, 1'b0);
    checkFlags("R10 flags after slot");
    tick;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 sdaPullLow", sdaPullLow, 1'b0);
    chk("R1 sclHoldLow", sclHoldLow, 1'b0);
    chk("R1 ackTime", ackTime, 1'b0);
    chk("R1 ackStatus", ackStatus, 1'b0);
    chk("R1 bufFull", bufFull, 1'b0);
    chk("R1 overflow", overflow, 1'b0);
    rstN = 1;
    tick;
    // R2 automatic ACK, data byte, empty buffer
    runByte(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R8 second byte while full: overflow, forced NACK (R6)
    runByte(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R9 clear both, then held address byte with ACK (R4, R5)
    runByte(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    runByte(1, 0, 1, 1, 0, 0, 4, 0, 0, 0);
    // R9 clear in same cycle as byte: set wins, forced NACK with ackTime (R6)
    runByte(1, 0, 0, 0, 1, 0, 0, 0, 1, 0);
    runByte(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    // R3 data byte: addrHoldEn set but data enable clear -> automatic ACK
    runByte(1, 0, 0, 1, 0, 0, 0, 0, 1, 0);
    runByte(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    // R5 held data byte with software NACK
    runByte(1, 0, 0, 0, 1, 1, 2, 0, 0, 0);
    runByte(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    // R10 transmit: master NACK then ACK
    runByte(1, 1, 0, 1, 1, 0, 0, 1, 0, 0);
    runByte(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R11 not addressed with hold enables set
    runByte(0, 0, 1, 1, 1, 0, 0, 1, 0, 0);
    for (int n = 0; n < 400; n++) begin
      runByte(($urandom % 8) != 0, ($urandom % 4) == 0, $urandom % 2, $urandom % 2,
              $urandom % 2, $urandom % 2, $urandom % 5, $urandom % 2,
              ($urandom % 3) == 0, ($urandom % 3) == 0);
    end
    summary;
  end

endmodule